// File: doc/BRIEF.md
# USB Start-of-Frame Number Tracker

This block sits behind a USB device core's token decoder. Each frame-start token arrives as a one-cycle strobe. The strobe carries an 11-bit frame field, the 5-bit check field as received, and a flag that marks the token as a high-speed micro-frame start rather than a full-speed frame start. The block verifies the token CRC5 and records the frame number or the micro-frame number. It also records whether the token was corrupted. It emits a one-cycle event for each token kind.

Software and neighbouring logic read the recorded state through a fixed 32-bit read-only status word. A free-running count of micro-frame tokens seen since the last full frame start is also provided. A synchronous USB bus-reset input returns the recorded state to zero.

Top module: `sof_tracker`

## Requirements
- R1: After power-on reset, the status word reads 0x00000000, both events are low and the micro-frame count is 0.
- R2: The status word has this layout. Bit 15 is the error flag. Bit 14 is zero. Bits 13..3 hold the frame number and bits 2..0 hold the micro-frame number. Bits 31..16 are zero.
- R3: On a full-frame token (`tok_micro`=0), the frame number takes `tok_frame`. The status word and `sof_evt` change one clock after the strobe. `sof_evt` is high for exactly that one cycle.
- R4: On a micro-frame token (`tok_micro`=1), the micro-frame number takes `tok_frame[2:0]`. The frame number is unchanged. `msof_evt` is high for one cycle, one clock after the strobe.
- R5: The CRC check runs the 11 frame bits LSB first, then `tok_crc[0]` through `tok_crc[4]`, through the CRC5 register. The register uses polynomial x^5+x^2+1 and is seeded with all ones. A token is valid when the final register is 5'b01100. `tok_crc[i]` is the inverse of bit 4-i of the CRC computed over the frame bits.
- R6: The error flag is rewritten on every token. It goes to 1 for a corrupted token and to 0 for a valid one. It updates in the same cycle as the event.
- R7: A corrupted token still updates the frame number or micro-frame number, and still raises its event.
- R8: Every full-frame token zeroes the micro-frame number.
- R9: `mf_count` is a 4-bit count of micro-frame tokens. It counts up by one per micro-frame token and wraps from 15 to 0. A full-frame token zeroes it.
- R10: A `bus_rst` cycle zeroes the frame number, the micro-frame number, the error flag and `mf_count`. A token strobe in that same cycle is discarded and raises no event.
- R11: With no strobe and no bus reset, the status word and `mf_count` hold and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | USB bus reset seen, synchronous, one or more cycles |
| tok_vld | input | 1 | Frame-start token strobe, one cycle |
| tok_micro | input | 1 | 1: micro-frame token, 0: full-frame token |
| tok_frame | input | 11 | Received frame field |
| tok_crc | input | 5 | Received check field, bit 0 first on the wire |
| stat_word | output | 32 | Read-only status word |
| sof_evt | output | 1 | One-cycle full-frame event |
| msof_evt | output | 1 | One-cycle micro-frame event |
| mf_count | output | 4 | Micro-frame tokens since the last full frame |

## Verification
The in-module properties run on every cycle. They check the fixed zero bits of the status word and that the two events never coincide. They check that each event traces back to a matching strobe that was not pre-empted by bus reset. They also check that a full-frame event always shows a zeroed micro-frame number and count, and that the state holds when idle or clears after bus reset. Only the bench scenarios can show the exact stored values. These are every one of the 2048 frame numbers, with correct and single-bit-corrupted check fields. The bench scenarios also cover the error flag following the CRC verdict token by token, the wrap of the micro-frame count, and reset-versus-strobe priority.

// File: rtl/sof_tracker.sv
module sof_tracker #(
  parameter int FRAME_W  = 11,
  parameter int MFRAME_W = 3,
  parameter int CRC_W    = 5,
  parameter int CNT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_rst,
  input  logic                 tok_vld,
  input  logic                 tok_micro,
  input  logic [FRAME_W-1:0]   tok_frame,
  input  logic [CRC_W-1:0]     tok_crc,
  output logic [31:0]          stat_word,
  output logic                 sof_evt,
  output logic                 msof_evt,
  output logic [CNT_W-1:0]     mf_count
);

  localparam int PAD_W = 32 - 2 - FRAME_W - MFRAME_W;
  localparam logic [CRC_W-1:0] POLY  = 5'b00101;
  localparam logic [CRC_W-1:0] RESID = 5'b01100;

  logic [FRAME_W-1:0]  fnum_q;
  logic [MFRAME_W-1:0] mfnum_q;
  logic                err_q;

  function automatic logic [CRC_W-1:0] crc_run(input logic [FRAME_W-1:0] d,
                                                input logic [CRC_W-1:0] c);
    logic [CRC_W-1:0] s;
    logic fb;
    s = '1;
    for (int i = 0; i < FRAME_W; i++) begin
      fb = d[i] ^ s[CRC_W-1];
      s  = {s[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    for (int i = 0; i < CRC_W; i++) begin
      fb = c[i] ^ s[CRC_W-1];
      s  = {s[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return s;
  endfunction

  logic crc_bad, take, take_sof, take_msof;
  assign crc_bad   = crc_run(tok_frame, tok_crc) != RESID;
  assign take      = tok_vld && !bus_rst;
  assign take_sof  = take && !tok_micro;
  assign take_msof = take && tok_micro;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fnum_q   <= '0;
      mfnum_q  <= '0;
      err_q    <= 1'b0;
      mf_count <= '0;
      sof_evt  <= 1'b0;
      msof_evt <= 1'b0;
    end else begin
      sof_evt  <= take_sof;
      msof_evt <= take_msof;
      if (bus_rst) begin
        fnum_q   <= '0;
        mfnum_q  <= '0;
        err_q    <= 1'b0;
        mf_count <= '0;
      end else if (take_sof) begin
        fnum_q   <= tok_frame;
        mfnum_q  <= '0;
        err_q    <= crc_bad;
        mf_count <= '0;
      end else if (take_msof) begin
        mfnum_q  <= tok_frame[MFRAME_W-1:0];
        err_q    <= crc_bad;
        mf_count <= mf_count + 1'b1;
      end
    end
  end

  assign stat_word = {{PAD_W{1'b0}}, err_q, 1'b0, fnum_q, mfnum_q};

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[31:16] == '0 && !stat_word[14]);

  // R3
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_evt, msof_evt}));

  // R3
  sof_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |-> $past(tok_vld && !tok_micro && !bus_rst));

  // R4
  msof_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msof_evt |-> $past(tok_vld && tok_micro && !bus_rst));

  // R8
  sof_clears_mf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |-> (stat_word[2:0] == '0 && mf_count == '0));

  // R4
  msof_keeps_fnum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msof_evt |-> $stable(stat_word[13:3]));

  // R10
  bus_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rst) |-> (stat_word == 32'h0 && mf_count == '0 && !sof_evt && !msof_evt));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tok_vld) && !$past(bus_rst)) |->
      ($stable(stat_word) && $stable(mf_count) && !sof_evt && !msof_evt));

endmodule

// File: tb/sof_tracker_tb.sv
`timescale 1ns/1ps
module sof_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 1'b0;
  logic tok_vld = 1'b0;
  logic tok_micro = 1'b0;
  logic [10:0] tok_frame = '0;
  logic [4:0]  tok_crc = '0;
  logic [31:0] stat_word;
  logic sof_evt, msof_evt;
  logic [3:0] mf_count;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sof_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .tok_vld(tok_vld),
    .tok_micro(tok_micro), .tok_frame(tok_frame), .tok_crc(tok_crc),
    .stat_word(stat_word), .sof_evt(sof_evt), .msof_evt(msof_evt),
    .mf_count(mf_count)
  );

  // R5: check field for a frame value, wire bit i = inverse of crc bit 4-i
  function automatic logic [4:0] good_crc(input logic [10:0] f);
    logic [4:0] c = 5'h1f;
    logic [4:0] o;
    for (int i = 0; i < 11; i++) begin
      if (f[i] ^ c[4]) c = {c[3:0], 1'b0} ^ 5'h05;
      else             c = {c[3:0], 1'b0};
    end
    for (int i = 0; i < 5; i++) o[i] = ~c[4-i];
    return o;
  endfunction

  function automatic logic [31:0] word(input logic e, input logic [10:0] f, input logic [2:0] m);
    return (32'(e) << 15) | (32'(f) << 3) | 32'(m);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic micro, input logic [10:0] f, input logic [4:0] c, input logic br);
    @(negedge clk);
    tok_vld = 1'b1; tok_micro = micro; tok_frame = f; tok_crc = c; bus_rst = br;
    @(negedge clk);
    tok_vld = 1'b0; bus_rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [10:0] f;
    logic [3:0] exp_cnt;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 status", stat_word, 32'h0);
    chk("R1 events", {sof_evt, msof_evt}, 0);
    chk("R1 count", mf_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R5 R6 R7 R2: all frame numbers, good then corrupted
    for (int i = 0; i < 2048; i++) begin
      f = 11'(i);
      send(1'b0, f, good_crc(f), 1'b0);
      chk("R3/R5 good sof", stat_word, word(1'b0, f, 3'd0));
      chk("R3 sof_evt", {sof_evt, msof_evt}, 2);
      send(1'b0, f, good_crc(f) ^ (5'd1 << (i % 5)), 1'b0);
      chk("R6/R7 bad sof", stat_word, word(1'b1, f, 3'd0));
      chk("R7 sof_evt bad", {sof_evt, msof_evt}, 2);
    end
    @(negedge clk);
    chk("R3 sof_evt one cycle", {sof_evt, msof_evt}, 0);

    // R4 R6 R9: micro tokens on top of frame 0x155
    send(1'b0, 11'h155, good_crc(11'h155), 1'b0);
    exp_cnt = 0;
    for (int m = 0; m < 8; m++) begin
      f = {8'(m * 37), 3'(m)};
      if (m % 2 == 0) send(1'b1, f, good_crc(f), 1'b0);
      else            send(1'b1, f, ~good_crc(f), 1'b0);
      exp_cnt++;
      chk("R4/R6 msof status", stat_word, word(m % 2 == 1, 11'h155, 3'(m)));
      chk("R4 msof_evt", {sof_evt, msof_evt}, 1);
      chk("R9 count", mf_count, exp_cnt);
    end
    // R11 idle hold
    repeat (3) @(negedge clk);
    chk("R11 hold status", stat_word, word(1'b1, 11'h155, 3'd7));
    chk("R11 hold count", mf_count, 8);
    chk("R11 no events", {sof_evt, msof_evt}, 0);

    // R9 wrap
    for (int k = 0; k < 10; k++) send(1'b1, 11'h3, good_crc(11'h3), 1'b0);
    chk("R9 wrap", mf_count, 4'd2);

    // R8
    send(1'b0, 11'h7ff, good_crc(11'h7ff), 1'b0);
    chk("R8 mfnum cleared", stat_word, word(1'b0, 11'h7ff, 3'd0));
    chk("R8/R9 count cleared", mf_count, 0);

    // R10 bus reset alone
    send(1'b1, 11'h5, ~good_crc(11'h5), 1'b0);
    chk("R10 pre", stat_word, word(1'b1, 11'h7ff, 3'd5));
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    chk("R10 cleared", stat_word, 32'h0);
    chk("R10 count", mf_count, 0);

    // R10 priority over strobe
    send(1'b0, 11'h2aa, ~good_crc(11'h2aa), 1'b0);
    send(1'b0, 11'h123, good_crc(11'h123), 1'b1);
    chk("R10 priority status", stat_word, 32'h0);
    chk("R10 priority events", {sof_evt, msof_evt}, 0);
    send(1'b1, 11'h6, good_crc(11'h6), 1'b1);
    chk("R10 micro discarded", stat_word, 32'h0);
    chk("R10 micro no evt", {sof_evt, msof_evt}, 0);
    chk("R10 micro count", mf_count, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule